// File: doc/BRIEF.md
# Indexed Segment Gather Load Sequencer

This block runs one indexed segment load for a vector unit. On a start pulse it takes a base address, a vector length, a data element width and an index element width. It also takes a field count, a destination register number, a register-group multiplier, a per-element enable mask and a packed vector of index values. For every enabled element it reads that element's byte offset from the index vector and adds it to the base. It then issues one scalar memory read per segment field, with the fields spaced one data element apart. Each returned datum is written into the right destination register at the element's slot.

The index width comes from the instruction variant and is independent of the data width. Progress is published on a restart-position output, so an interrupted sequence can be resumed from the last element that was begun. Illegal register overlap is rejected before any memory traffic. Memory reads go out one at a time over a valid/ready request channel, and each returns on a response strobe.

Top module: `vgather_seg_seq`

## Requirements
- R1: The number of fields per element is `nf_field + 1` (1 to 8). Each enabled element gives exactly that many memory reads and that many register writes.
- R2: `idx_eew` selects the index width as 0=1, 1=2, 2=4 or 3=8 bytes. Index element i occupies bytes i×width upward of `idx_vec`, least significant byte first (byte b is bits 8b+7..8b). The index is zero-extended before use.
- R3: The read address for element i and field f is `base_addr + index[i] + f × 2^sew`, modulo 2^ADDR_W. `mem_req_size` carries the `sew` code (0=1, 1=2, 2=4, 3=8 bytes).
- R4: The datum for field f of element i is written to register `(vd + f × 2^lmul) mod 32` at `rf_elem = i`. The written value is the low 2^sew bytes of `mem_rsp_data`, and all higher bits are zero.
- R5: Accesses run with elements in ascending order and, within each element, fields in ascending order.
- R6: An element with `mask[i] = 0` causes no memory read and no register write.
- R7: While the accesses of element i are under way, `vstart` equals i. When the sequence completes, `vstart` is 0 in the cycle where `done` is high.
- R8: When `nf_field ≥ 1` and `idx_reg` lies within [vd, vd + (nf_field+1)×2^lmul), the operation is rejected. `done` and `illegal` are then high in the cycle after start, with no memory read and no register write. With `nf_field = 0` the overlap is allowed.
- R9: With `vl = 0`, `done` is high in the cycle after start and no memory read occurs.
- R10: At most one read is outstanding at a time. A request that is not accepted stays valid with an unchanged address.
- R11: `done` is a single-cycle pulse. A start pulse while a sequence is running is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a sequence (taken only when idle) |
| base_addr | input | ADDR_W | Base address |
| vl | input | VL_W | Number of elements |
| sew | input | 2 | Data element width code |
| idx_eew | input | 2 | Index element width code |
| nf_field | input | 3 | Field count minus one |
| vd | input | 5 | First destination register |
| lmul | input | 2 | Log2 of register-group size |
| idx_reg | input | 5 | Register holding the indices (overlap check) |
| mask | input | MAX_VL | Per-element enable, held through the sequence |
| idx_vec | input | MAX_VL×64 | Packed index bytes, held through the sequence |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_ready | input | 1 | Read request accepted |
| mem_req_addr | output | ADDR_W | Read address |
| mem_req_size | output | 2 | Read size code |
| mem_rsp_valid | input | 1 | Read data strobe |
| mem_rsp_data | input | 64 | Read data |
| rf_we | output | 1 | Register write strobe |
| rf_reg | output | 5 | Destination register |
| rf_elem | output | EL_W | Element slot |
| rf_data | output | 64 | Write data |
| vstart | output | EL_W | Restart position |
| done | output | 1 | Sequence finished |
| illegal | output | 1 | Sequence rejected for overlap |

## Verification
Random operations mix every pairing of index width and data width, so a datum read through the wrong index width or with the wrong field stride shows up as an address mismatch. Random masks with field counts up to eight and every group multiplier separate skipping errors from register-numbering errors, and the modulo-32 register wrap is also exercised. Directed cases cover a zero length, an all-zero mask, an overlap rejection against an allowed single-field overlap, and 8-byte indices that wrap the address. A second start pulse mid-sequence is also applied; if the block restarted, the count of writes would not match.

// File: rtl/vgs_pkg.sv
package vgs_pkg;

    localparam int VGS_DATA_W = 64;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SCAN,
        ST_ISSUE,
        ST_WAIT
    } vgs_state_e;

    typedef struct packed {
        logic [1:0] sew;
        logic [1:0] eew;
        logic [2:0] nf_last;
        logic [4:0] vd;
        logic [1:0] lmul;
    } vgs_op_t;

    function automatic logic [VGS_DATA_W-1:0] vgs_size_mask(input logic [1:0] code);
        case (code)
            2'd0:    return 64'h0000_0000_0000_00FF;
            2'd1:    return 64'h0000_0000_0000_FFFF;
            2'd2:    return 64'h0000_0000_FFFF_FFFF;
            default: return 64'hFFFF_FFFF_FFFF_FFFF;
        endcase
    endfunction

    function automatic logic [6:0] vgs_group_span(input logic [2:0] nf_last,
                                                  input logic [1:0] lmul);
        return ({4'd0, nf_last} + 7'd1) << lmul;
    endfunction

endpackage

// File: rtl/vgs_index_pick.sv
module vgs_index_pick #(
    parameter int MAX_VL = 16,
    parameter int ADDR_W = 32,
    localparam int EL_W  = $clog2(MAX_VL)
) (
    input  logic [MAX_VL*64-1:0] idx_vec,
    input  logic [1:0]           eew,
    input  logic [EL_W-1:0]      elem,
    output logic [ADDR_W-1:0]    idx_ext
);
    logic [63:0] cand [4];

    for (genvar w = 0; w < 4; w++) begin : g_width
        localparam int NBITS = 8 << w;
        logic [NBITS-1:0] lanes [MAX_VL];
        for (genvar e = 0; e < MAX_VL; e++) begin : g_lane
            assign lanes[e] = idx_vec[e*NBITS +: NBITS];
        end
        assign cand[w] = 64'(lanes[elem]);
    end

    assign idx_ext = ADDR_W'(cand[eew]);
endmodule

// File: rtl/vgs_addr_gen.sv
module vgs_addr_gen #(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] idx_ext,
    input  logic [2:0]        field,
    input  logic [1:0]        sew,
    input  logic [4:0]        vd,
    input  logic [1:0]        lmul,
    output logic [ADDR_W-1:0] addr,
    output logic [4:0]        dreg
);
    logic [ADDR_W-1:0] field_off;
    logic [5:0]        reg_off;

    always_comb begin
        field_off = ADDR_W'(field) << sew;
        reg_off   = {3'd0, field} << lmul;
        addr      = base + idx_ext + field_off;
        dreg      = vd + reg_off[4:0];
    end
endmodule

// File: rtl/vgs_overlap_chk.sv
module vgs_overlap_chk
    import vgs_pkg::*;
(
    input  logic [2:0] nf_last,
    input  logic [4:0] vd,
    input  logic [1:0] lmul,
    input  logic [4:0] idx_reg,
    output logic       clash
);
    logic [6:0] grp_end;
    logic [6:0] ir_w;
    logic [6:0] vd_w;

    always_comb begin
        vd_w    = {2'd0, vd};
        ir_w    = {2'd0, idx_reg};
        grp_end = vd_w + vgs_group_span(nf_last, lmul);
        clash   = (nf_last != 3'd0) && (ir_w >= vd_w) && (ir_w < grp_end);
    end
endmodule

// File: rtl/vgather_seg_seq.sv
module vgather_seg_seq
    import vgs_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int MAX_VL = 16,
    localparam int VL_W  = $clog2(MAX_VL + 1),
    localparam int EL_W  = $clog2(MAX_VL)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start,
    input  logic [ADDR_W-1:0]     base_addr,
    input  logic [VL_W-1:0]       vl,
    input  logic [1:0]            sew,
    input  logic [1:0]            idx_eew,
    input  logic [2:0]            nf_field,
    input  logic [4:0]            vd,
    input  logic [1:0]            lmul,
    input  logic [4:0]            idx_reg,
    input  logic [MAX_VL-1:0]     mask,
    input  logic [MAX_VL*64-1:0]  idx_vec,
    output logic                  mem_req_valid,
    input  logic                  mem_req_ready,
    output logic [ADDR_W-1:0]     mem_req_addr,
    output logic [1:0]            mem_req_size,
    input  logic                  mem_rsp_valid,
    input  logic [63:0]           mem_rsp_data,
    output logic                  rf_we,
    output logic [4:0]            rf_reg,
    output logic [EL_W-1:0]       rf_elem,
    output logic [63:0]           rf_data,
    output logic [EL_W-1:0]       vstart,
    output logic                  done,
    output logic                  illegal
);
    localparam logic [VL_W-1:0] VL_CAP = VL_W'(MAX_VL);

    vgs_state_e        state_q;
    vgs_op_t           op_q;
    logic [ADDR_W-1:0] base_q;
    logic [VL_W-1:0]   vl_q;
    logic [VL_W-1:0]   elem_q;
    logic [2:0]        fld_q;
    logic [EL_W-1:0]   vstart_q;
    logic              done_q;
    logic              illegal_q;
    logic              rf_we_q;
    logic [4:0]        rf_reg_q;
    logic [EL_W-1:0]   rf_elem_q;
    logic [63:0]       rf_data_q;

    logic [EL_W-1:0]   elem_slot;
    logic [ADDR_W-1:0] idx_ext;
    logic [ADDR_W-1:0] acc_addr;
    logic [4:0]        acc_reg;
    logic              clash;
    logic              elem_on;
    logic              last_elem;
    logic              last_field;

    assign elem_slot = elem_q[EL_W-1:0];

    vgs_index_pick #(.MAX_VL(MAX_VL), .ADDR_W(ADDR_W)) u_pick (
        .idx_vec (idx_vec),
        .eew     (op_q.eew),
        .elem    (elem_slot),
        .idx_ext (idx_ext)
    );

    vgs_addr_gen #(.ADDR_W(ADDR_W)) u_agen (
        .base    (base_q),
        .idx_ext (idx_ext),
        .field   (fld_q),
        .sew     (op_q.sew),
        .vd      (op_q.vd),
        .lmul    (op_q.lmul),
        .addr    (acc_addr),
        .dreg    (acc_reg)
    );

    vgs_overlap_chk u_ovl (
        .nf_last (nf_field),
        .vd      (vd),
        .lmul    (lmul),
        .idx_reg (idx_reg),
        .clash   (clash)
    );

    always_comb begin
        last_elem  = (elem_q == vl_q);
        elem_on    = mask[elem_slot];
        last_field = (fld_q == op_q.nf_last);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            op_q      <= '0;
            base_q    <= '0;
            vl_q      <= '0;
            elem_q    <= '0;
            fld_q     <= '0;
            vstart_q  <= '0;
            done_q    <= 1'b0;
            illegal_q <= 1'b0;
            rf_we_q   <= 1'b0;
            rf_reg_q  <= '0;
            rf_elem_q <= '0;
            rf_data_q <= '0;
        end else begin
            done_q    <= 1'b0;
            illegal_q <= 1'b0;
            rf_we_q   <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        op_q.sew     <= sew;
                        op_q.eew     <= idx_eew;
                        op_q.nf_last <= nf_field;
                        op_q.vd      <= vd;
                        op_q.lmul    <= lmul;
                        base_q       <= base_addr;
                        vl_q         <= (vl > VL_CAP) ? VL_CAP : vl;
                        elem_q       <= '0;
                        fld_q        <= '0;
                        if (clash) begin
                            done_q    <= 1'b1;
                            illegal_q <= 1'b1;
                        end else if (vl == '0) begin
                            done_q   <= 1'b1;
                            vstart_q <= '0;
                        end else begin
                            state_q <= ST_SCAN;
                        end
                    end
                end
                ST_SCAN: begin
                    if (last_elem) begin
                        done_q   <= 1'b1;
                        vstart_q <= '0;
                        state_q  <= ST_IDLE;
                    end else if (!elem_on) begin
                        elem_q <= elem_q + VL_W'(1);
                    end else begin
                        vstart_q <= elem_slot;
                        fld_q    <= '0;
                        state_q  <= ST_ISSUE;
                    end
                end
                ST_ISSUE: begin
                    if (mem_req_ready) begin
                        state_q <= ST_WAIT;
                    end
                end
                ST_WAIT: begin
                    if (mem_rsp_valid) begin
                        rf_we_q   <= 1'b1;
                        rf_reg_q  <= acc_reg;
                        rf_elem_q <= elem_slot;
                        rf_data_q <= mem_rsp_data & vgs_size_mask(op_q.sew);
                        if (last_field) begin
                            elem_q  <= elem_q + VL_W'(1);
                            state_q <= ST_SCAN;
                        end else begin
                            fld_q   <= fld_q + 3'd1;
                            state_q <= ST_ISSUE;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign mem_req_valid = (state_q == ST_ISSUE);
    assign mem_req_addr  = acc_addr;
    assign mem_req_size  = op_q.sew;
    assign rf_we         = rf_we_q;
    assign rf_reg        = rf_reg_q;
    assign rf_elem       = rf_elem_q;
    assign rf_data       = rf_data_q;
    assign vstart        = vstart_q;
    assign done          = done_q;
    assign illegal       = illegal_q;
endmodule

// File: rtl/vgs_sva.sv
module vgs_sva #(
    parameter int ADDR_W = 32,
    parameter int MAX_VL = 16,
    localparam int EL_W  = $clog2(MAX_VL)
) (
    input logic              clk,
    input logic              rst,
    input logic [1:0]        sew,
    input logic [MAX_VL-1:0] mask,
    input logic              mem_req_valid,
    input logic              mem_req_ready,
    input logic [ADDR_W-1:0] mem_req_addr,
    input logic              mem_rsp_valid,
    input logic              rf_we,
    input logic [EL_W-1:0]   rf_elem,
    input logic [63:0]       rf_data,
    input logic [EL_W-1:0]   vstart,
    input logic              done,
    input logic              illegal
);
    logic [1:0] outstanding;

    always_ff @(posedge clk) begin
        if (rst) begin
            outstanding <= '0;
        end else begin
            outstanding <= outstanding
                         + 2'(mem_req_valid && mem_req_ready)
                         - 2'(mem_rsp_valid && (outstanding != 2'd0));
        end
    end

    // R10: a stalled request keeps its address
    a_r10_req_hold: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

    // R10: no new request while one is outstanding
    a_r10_single_outstanding: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |-> outstanding == 2'd0);

    // R11: done lasts one cycle
    a_r11_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R7: restart position is cleared at completion
    a_r7_vstart_clear: assert property (@(posedge clk) disable iff (rst)
        done |-> vstart == '0);

    // R8: rejection is reported with completion
    a_r8_illegal_with_done: assert property (@(posedge clk) disable iff (rst)
        illegal |-> done);

    // R6: only enabled elements are written
    a_r6_no_masked_write: assert property (@(posedge clk) disable iff (rst)
        rf_we |-> mask[rf_elem]);

    // R4: a byte-wide write has clear upper bits
    a_r4_byte_upper_zero: assert property (@(posedge clk) disable iff (rst)
        rf_we && sew == 2'd0 |-> rf_data[63:8] == 56'd0);
endmodule

bind vgather_seg_seq vgs_sva #(.ADDR_W(ADDR_W), .MAX_VL(MAX_VL)) u_sva (
    .clk           (clk),
    .rst           (rst),
    .sew           (sew),
    .mask          (mask),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .rf_we         (rf_we),
    .rf_elem       (rf_elem),
    .rf_data       (rf_data),
    .vstart        (vstart),
    .done          (done),
    .illegal       (illegal)
);

// File: tb/sim_vgather_seg_seq.sv
`timescale 1ns/1ps
module sim_vgather_seg_seq;
    localparam int AW   = 32;
    localparam int MVL  = 16;
    localparam int VLW  = $clog2(MVL + 1);
    localparam int ELW  = $clog2(MVL);
    localparam int MAXT = MVL * 8;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            start = 1'b0;
    logic [AW-1:0]   base_addr = '0;
    logic [VLW-1:0]  vl = '0;
    logic [1:0]      sew = '0;
    logic [1:0]      idx_eew = '0;
    logic [2:0]      nf_field = '0;
    logic [4:0]      vd = '0;
    logic [1:0]      lmul = '0;
    logic [4:0]      idx_reg = '0;
    logic [MVL-1:0]  mask = '0;
    logic [MVL*64-1:0] idx_vec = '0;
    logic            mem_req_valid;
    logic            mem_req_ready = 1'b0;
    logic [AW-1:0]   mem_req_addr;
    logic [1:0]      mem_req_size;
    logic            mem_rsp_valid = 1'b0;
    logic [63:0]     mem_rsp_data = '0;
    logic            rf_we;
    logic [4:0]      rf_reg;
    logic [ELW-1:0]  rf_elem;
    logic [63:0]     rf_data;
    logic [ELW-1:0]  vstart;
    logic            done;
    logic            illegal;

    int checks = 0;
    int errors = 0;

    logic [AW-1:0]  exp_addr [MAXT];
    logic [4:0]     exp_reg  [MAXT];
    logic [ELW-1:0] exp_elem [MAXT];
    int exp_n = 0;
    int req_ptr = 0;
    int wr_ptr = 0;
    int resp_cnt = 0;
    logic [AW-1:0] pend_addr = '0;

    always #10 clk = ~clk;

    vgather_seg_seq #(.ADDR_W(AW), .MAX_VL(MVL)) u0 (
        .clk(clk), .rst(rst), .start(start), .base_addr(base_addr), .vl(vl),
        .sew(sew), .idx_eew(idx_eew), .nf_field(nf_field), .vd(vd), .lmul(lmul),
        .idx_reg(idx_reg), .mask(mask), .idx_vec(idx_vec),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_req_size(mem_req_size),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .rf_we(rf_we), .rf_reg(rf_reg), .rf_elem(rf_elem), .rf_data(rf_data),
        .vstart(vstart), .done(done), .illegal(illegal)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    function automatic logic [63:0] mdata(input logic [AW-1:0] a);
        return {a ^ 32'hA5C3_0F17, ~a + 32'h0101_0101};
    endfunction

    function automatic logic [63:0] smask(input logic [1:0] c);
        return (c == 2'd3) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << (8 << c)) - 64'd1);
    endfunction

    function automatic bit exp_clash();
        int span = (int'(nf_field) + 1) << lmul;
        return (nf_field != 0) && (int'(idx_reg) >= int'(vd)) &&
               (int'(idx_reg) < int'(vd) + span);
    endfunction

    task automatic build_expected();
        exp_n = 0;
        if (exp_clash()) return;
        for (int i = 0; i < int'(vl) && i < MVL; i++) begin
            if (mask[i]) begin
                int nb = 1 << idx_eew;
                logic [63:0] ix = '0;
                for (int b = 0; b < nb; b++)
                    ix |= 64'(idx_vec[(i*nb + b)*8 +: 8]) << (8*b);
                for (int f = 0; f <= int'(nf_field); f++) begin
                    exp_addr[exp_n] = AW'(64'(base_addr) + ix + (64'(f) << sew));
                    exp_reg[exp_n]  = 5'(int'(vd) + (f << lmul));
                    exp_elem[exp_n] = ELW'(i);
                    exp_n++;
                end
            end
        end
    endtask

    // memory model and output monitor, all on the falling edge
    initial begin
        forever begin
            @(negedge clk);
            if (rf_we) begin
                if (wr_ptr < exp_n) begin
                    chk(rf_reg == exp_reg[wr_ptr], "R4 dest reg", 64'(rf_reg), 64'(exp_reg[wr_ptr]));
                    chk(rf_elem == exp_elem[wr_ptr], "R4/R5 elem slot", 64'(rf_elem), 64'(exp_elem[wr_ptr]));
                    chk(rf_data == (mdata(exp_addr[wr_ptr]) & smask(sew)), "R4 write data",
                        rf_data, mdata(exp_addr[wr_ptr]) & smask(sew));
                end else begin
                    chk(1'b0, "R6 unexpected write", 64'(wr_ptr), 64'(exp_n));
                end
                wr_ptr++;
            end
            mem_rsp_valid = 1'b0;
            if (mem_req_valid && resp_cnt != 0)
                chk(1'b0, "R10 second outstanding read", 64'(resp_cnt), 64'd0);
            if (resp_cnt > 0) begin
                resp_cnt--;
                if (resp_cnt == 0) begin
                    mem_rsp_valid = 1'b1;
                    mem_rsp_data  = mdata(pend_addr);
                end
            end
            mem_req_ready = 1'b0;
            if (mem_req_valid && resp_cnt == 0 && !mem_rsp_valid) begin
                mem_req_ready = ($urandom % 3) != 0;
                if (mem_req_ready) begin
                    if (req_ptr < exp_n) begin
                        chk(mem_req_addr == exp_addr[req_ptr], "R3/R5 address",
                            64'(mem_req_addr), 64'(exp_addr[req_ptr]));
                        chk(mem_req_size == sew, "R3 size", 64'(mem_req_size), 64'(sew));
                        chk(vstart == exp_elem[req_ptr], "R7 vstart", 64'(vstart), 64'(exp_elem[req_ptr]));
                    end else begin
                        chk(1'b0, "R6 unexpected read", 64'(req_ptr), 64'(exp_n));
                    end
                    pend_addr = mem_req_addr;
                    req_ptr++;
                    resp_cnt = 1 + int'($urandom % 3);
                end
            end
        end
    end

    task automatic run_op(input bit repulse);
        int cyc = 0;
        bit ill_exp;
        build_expected();
        ill_exp = exp_clash();
        req_ptr = 0;
        wr_ptr = 0;
        @(negedge clk);
        start = 1'b1;
        forever begin
            @(negedge clk);
            cyc++;
            start = repulse && (cyc == 3);
            if (done || cyc > 3000) break;
        end
        start = 1'b0;
        chk(cyc <= 3000, "R1 completion", 64'(cyc), 64'd3000);
        if (ill_exp || vl == 0)
            chk(cyc == 1, "R8/R9 done latency", 64'(cyc), 64'd1);
        chk(illegal == ill_exp, "R8 illegal flag", 64'(illegal), 64'(ill_exp));
        chk(vstart == 0, "R7 vstart cleared", 64'(vstart), 64'd0);
        chk(req_ptr == exp_n, "R1/R6 read count", 64'(req_ptr), 64'(exp_n));
        chk(wr_ptr == exp_n, "R1/R6 write count", 64'(wr_ptr), 64'(exp_n));
        @(negedge clk);
        chk(!done, "R11 done pulse", 64'(done), 64'd0);
    endtask

    task automatic fill_idx();
        for (int k = 0; k < MVL*2; k++) idx_vec[k*32 +: 32] = $urandom;
    endtask

    task automatic set_op(input logic [AW-1:0] b, input int n, input int s, input int e,
                          input int nf, input int d, input int lm, input int ir,
                          input logic [MVL-1:0] m);
        base_addr = b; vl = VLW'(n); sew = 2'(s); idx_eew = 2'(e); nf_field = 3'(nf);
        vd = 5'(d); lmul = 2'(lm); idx_reg = 5'(ir); mask = m;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!done && !illegal && !mem_req_valid && !rf_we && vstart == 0,
            "reset state", {59'd0, done, illegal, mem_req_valid, rf_we, 1'b0}, 64'd0);
        fill_idx();
        // R9: zero length
        set_op(32'h1000, 0, 2, 1, 2, 8, 0, 1, '1);
        run_op(1'b0);
        // R8: field group 4..7 covers index register 6
        set_op(32'h1000, 5, 1, 0, 1, 4, 1, 6, '1);
        run_op(1'b0);
        // R8: single field overlap is legal
        set_op(32'h2000, 4, 0, 0, 0, 9, 0, 9, '1);
        run_op(1'b0);
        // R6: all elements disabled
        set_op(32'h3000, 12, 3, 2, 3, 2, 0, 30, '0);
        run_op(1'b0);
        // R2/R3: 8-byte indices with address wrap
        for (int k = 0; k < MVL; k++) idx_vec[k*64 +: 64] = 64'hFFFF_FFFF_FFFF_FF00 + 64'(k);
        set_op(32'h0000_0200, 6, 2, 3, 2, 1, 0, 20, 16'h0035);
        run_op(1'b0);
        // R4: register wrap at 32 with group of 8
        fill_idx();
        set_op(32'h4000, 3, 1, 1, 2, 24, 3, 2, '1);
        run_op(1'b0);
        // R11: second start mid-sequence
        set_op(32'h5000, 8, 0, 0, 1, 10, 0, 0, '1);
        run_op(1'b1);
        for (int t = 0; t < 40; t++) begin
            fill_idx();
            set_op($urandom, int'($urandom % (MVL + 1)), int'($urandom % 4),
                   int'($urandom % 4), int'($urandom % 8), int'($urandom % 32),
                   int'($urandom % 4), int'($urandom % 32),
                   (t % 4 == 0) ? '1 : MVL'($urandom));
            run_op(1'b0);
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule